// File: doc/BRIEF.md
# DMA Port Handshake Engine

This block moves bytes between an external 16-bit DMA port and an internal FIFO. Each transfer on the port is a handshake beat made of a request, an active-low acknowledge and one of two active-low strobes. A DMA sequencer loads a byte count with a start pulse. The block runs beats until the count is used up or a stop input arrives. It then holds a done flag, together with a bit that records why the transfer ended.

Three static configuration inputs set the operating mode. The first picks the beat width: one byte on bits 7:0, or two bytes on the full bus. The second picks the handshake role. As initiator the block drives request, acknowledge and strobe itself. As responder it raises request to show it is ready, and the external device supplies acknowledge and strobe. The third picks the direction, port into FIFO or FIFO out to port. Before each beat the block checks the FIFO. If the FIFO is full when filling, or empty when draining, no new beat starts. The engine waits and carries on once the condition clears.

Top module: `dma_port_hs`

## Requirements
- R1: While reset is high, and in the first cycle after it, busy, done, request, FIFO push and FIFO pop are 0; acknowledge, both strobes are 1 and the bus output enable is 0.
- R2: With cfg_master=1, each beat raises port_req_o one cycle before port_ack_n_o and the strobe go low together for exactly one cycle. The strobe is port_wr_n_o when cfg_to_fifo=1 and port_rd_n_o when cfg_to_fifo=0. Each beat performs exactly one FIFO push (cfg_to_fifo=1) or one FIFO pop (cfg_to_fifo=0).
- R3: With cfg_master=0, the block raises port_req_o when ready and keeps port_ack_n_o, port_rd_n_o and port_wr_n_o at 1. A beat completes once both port_ack_n_i and the direction's strobe input have passed a two-flop synchronizer and read low. The next beat waits until the synchronized acknowledge has returned high.
- R4: With cfg_wide=1, a beat moves all 16 bits and takes 2 from the byte count. With cfg_wide=0, a beat moves bits 7:0, takes 1 from the count, and bits 15:8 are 0 on port_d_o and on fifo_wdata.
- R5: start_count is loaded on start. The transfer ends after ceil(count / bytes per beat) beats, with done=1, busy=0 and done_by_stop=0. A count of 0 ends the transfer with no beat.
- R6: A stop pulse during a transfer ends it at the next beat boundary, with done=1 and done_by_stop=1. A beat that has already begun completes.
- R7: No beat starts, and port_req_o stays 0, while fifo_full=1 (cfg_to_fifo=1) or fifo_empty=1 (cfg_to_fifo=0). Beats resume by themselves once the flag drops.
- R8: port_d_oe is 1 only when cfg_to_fifo=0 and the read strobe is low: the block's own port_rd_n_o when cfg_master=1, or port_rd_n_i when cfg_master=0.
- R9: A start pulse while busy=1 is ignored; the running transfer keeps its count.
- R10: fifo_pop is never asserted while fifo_empty=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_master | input | 1 | 1 = block drives the handshake, 0 = external device drives it |
| cfg_wide | input | 1 | 1 = 16-bit beats, 0 = 8-bit beats on bits 7:0 |
| cfg_to_fifo | input | 1 | 1 = port into FIFO, 0 = FIFO out to port |
| start | input | 1 | Start pulse, loads start_count |
| stop | input | 1 | Stop-operation pulse |
| start_count | input | CNT_W | Byte count of the transfer |
| port_req_o | output | 1 | Request / ready to the port |
| port_ack_n_o | output | 1 | Acknowledge driven in initiator role, active low |
| port_rd_n_o | output | 1 | Read strobe driven in initiator role, active low |
| port_wr_n_o | output | 1 | Write strobe driven in initiator role, active low |
| port_ack_n_i | input | 1 | Acknowledge from the port in responder role, active low |
| port_rd_n_i | input | 1 | Read strobe from the port in responder role, active low |
| port_wr_n_i | input | 1 | Write strobe from the port in responder role, active low |
| port_d_i | input | 16 | Port bus input |
| port_d_o | output | 16 | Port bus output |
| port_d_oe | output | 1 | Port bus output enable |
| fifo_full | input | 1 | FIFO cannot accept data |
| fifo_empty | input | 1 | FIFO holds no data |
| fifo_rdata | input | 16 | FIFO head entry, valid while not empty |
| fifo_push | output | 1 | Write fifo_wdata into the FIFO |
| fifo_wdata | output | 16 | FIFO write data |
| fifo_pop | output | 1 | Remove the FIFO head |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer ended, held until next start |
| done_by_stop | output | 1 | 1 = ended by stop, 0 = count reached zero |

## Verification
The hardest case to reach is a transfer in the responder role. There, every beat depends on the external device: it must see request, drive acknowledge and the strobe long enough to cross the synchronizer, and then release both before the next request. The bench builds this with a separate process that acts as the external initiator. The process is enabled only for responder vectors and holds the strobes for a fixed number of cycles. Stop and FIFO stalls are reached with directed tests. These raise the stall flag before start, or pulse stop part way through a long transfer, and then count the beats that actually happened.

// File: rtl/dph_pkg.sv
package dph_pkg;
    localparam int PORT_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_REQ,
        ST_STB,
        ST_REL
    } dph_state_e;

    typedef struct packed {
        logic master;
        logic wide;
        logic to_fifo;
    } dph_cfg_t;

    function automatic logic [PORT_W-1:0] lane_mask(input logic [PORT_W-1:0] d,
                                                    input logic wide);
        return wide ? d : {{(PORT_W-BYTE_W){1'b0}}, d[BYTE_W-1:0]};
    endfunction
endpackage

// File: rtl/dph_sync.sv
module dph_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= RST_VAL;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dph_bytecnt.sv
module dph_bytecnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    input  logic             wide,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] step;

    assign step = wide ? CNT_W'(2) : CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (dec) begin
            if (cnt_q <= step)  cnt_q <= '0;
            else                cnt_q <= cnt_q - step;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dph_ctrl.sv
module dph_ctrl
    import dph_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  dph_cfg_t   cfg,
    input  logic       start,
    input  logic       stop,
    input  logic       cnt_zero,
    input  logic       fifo_full,
    input  logic       fifo_empty,
    input  logic       ack_s,
    input  logic       stb_s,
    output dph_state_e state_o,
    output logic       load_o,
    output logic       beat_done_o,
    output logic       pop_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       by_stop_o
);
    dph_state_e state_q, state_d;
    logic stop_pend_q, done_q, by_stop_q;
    logic blocked, stop_any, finish, go;

    assign blocked  = cfg.to_fifo ? fifo_full : fifo_empty;
    assign stop_any = stop | stop_pend_q;
    assign finish   = (state_q == ST_WAIT) && (cnt_zero || stop_any);
    assign go       = (state_q == ST_WAIT) && !finish && !blocked;

    assign load_o      = (state_q == ST_IDLE) && start;
    assign pop_o       = go && !cfg.to_fifo;
    assign beat_done_o = (state_q == ST_STB) ||
                         ((state_q == ST_REQ) && !cfg.master && !ack_s && !stb_s);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (start) state_d = ST_WAIT;
            ST_WAIT: begin
                if (finish)  state_d = ST_IDLE;
                else if (go) state_d = ST_REQ;
            end
            ST_REQ: begin
                if (cfg.master)          state_d = ST_STB;
                else if (beat_done_o)    state_d = ST_REL;
            end
            ST_STB:  state_d = ST_WAIT;
            ST_REL:  if (ack_s) state_d = ST_WAIT;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            stop_pend_q <= 1'b0;
            done_q      <= 1'b0;
            by_stop_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load_o) begin
                stop_pend_q <= 1'b0;
                done_q      <= 1'b0;
                by_stop_q   <= 1'b0;
            end else begin
                if (stop && state_q != ST_IDLE) stop_pend_q <= 1'b1;
                if (finish) begin
                    done_q    <= 1'b1;
                    by_stop_q <= !cnt_zero;
                end
            end
        end
    end

    assign state_o   = state_q;
    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = done_q;
    assign by_stop_o = by_stop_q;
endmodule

// File: rtl/dma_port_hs.sv
module dma_port_hs
    import dph_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_master,
    input  logic             cfg_wide,
    input  logic             cfg_to_fifo,
    input  logic             start,
    input  logic             stop,
    input  logic [CNT_W-1:0] start_count,
    output logic             port_req_o,
    output logic             port_ack_n_o,
    output logic             port_rd_n_o,
    output logic             port_wr_n_o,
    input  logic             port_ack_n_i,
    input  logic             port_rd_n_i,
    input  logic             port_wr_n_i,
    input  logic [15:0]      port_d_i,
    output logic [15:0]      port_d_o,
    output logic             port_d_oe,
    input  logic             fifo_full,
    input  logic             fifo_empty,
    input  logic [15:0]      fifo_rdata,
    output logic             fifo_push,
    output logic [15:0]      fifo_wdata,
    output logic             fifo_pop,
    output logic             busy,
    output logic             done,
    output logic             done_by_stop
);
    localparam int HS_W = 3;

    dph_cfg_t         cfg;
    dph_state_e       state;
    logic [HS_W-1:0]  hs_s;
    logic             ack_s, rd_s, wr_s, stb_s;
    logic             load, beat_done, pop, cnt_zero;
    logic [PORT_W-1:0] out_q;
    logic             strobing;

    assign cfg = '{master: cfg_master, wide: cfg_wide, to_fifo: cfg_to_fifo};

    dph_sync #(.W(HS_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({port_ack_n_i, port_rd_n_i, port_wr_n_i}),
        .q_o (hs_s)
    );
    assign {ack_s, rd_s, wr_s} = hs_s;
    assign stb_s = cfg.to_fifo ? wr_s : rd_s;

    dph_bytecnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (start_count),
        .dec      (beat_done),
        .wide     (cfg.wide),
        .zero_o   (cnt_zero)
    );

    dph_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cfg         (cfg),
        .start       (start),
        .stop        (stop),
        .cnt_zero    (cnt_zero),
        .fifo_full   (fifo_full),
        .fifo_empty  (fifo_empty),
        .ack_s       (ack_s),
        .stb_s       (stb_s),
        .state_o     (state),
        .load_o      (load),
        .beat_done_o (beat_done),
        .pop_o       (pop),
        .busy_o      (busy),
        .done_o      (done),
        .by_stop_o   (done_by_stop)
    );

    always_ff @(posedge clk) begin
        if (rst)      out_q <= '0;
        else if (pop) out_q <= lane_mask(fifo_rdata, cfg.wide);
    end

    assign strobing     = (state == ST_STB);
    assign port_req_o   = (state == ST_REQ) || strobing;
    assign port_ack_n_o = !strobing;
    assign port_rd_n_o  = !(strobing && !cfg.to_fifo);
    assign port_wr_n_o  = !(strobing && cfg.to_fifo);

    assign port_d_oe = !cfg.to_fifo &&
                       (cfg.master ? strobing
                                   : (!port_rd_n_i && (state == ST_REQ || state == ST_REL)));
    assign port_d_o  = out_q;

    assign fifo_push  = cfg.to_fifo && beat_done;
    assign fifo_wdata = lane_mask(port_d_i, cfg.wide);
    assign fifo_pop   = pop;
endmodule

// File: rtl/dma_port_hs_chk.sv
module dma_port_hs_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_master,
    input logic             cfg_wide,
    input logic             cfg_to_fifo,
    input logic             port_req_o,
    input logic             port_ack_n_o,
    input logic             port_rd_n_o,
    input logic             port_wr_n_o,
    input logic             port_rd_n_i,
    input logic [15:0]      port_d_o,
    input logic             port_d_oe,
    input logic             fifo_empty,
    input logic             fifo_push,
    input logic [15:0]      fifo_wdata,
    input logic             fifo_pop,
    input logic             busy,
    input logic             done
);
    a_r10_pop_not_empty: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> !fifo_empty);

    a_r8_oe_strobe: assert property (@(posedge clk) disable iff (rst)
        port_d_oe |-> (!cfg_to_fifo && (cfg_master ? !port_rd_n_o : !port_rd_n_i)));

    a_r4_narrow_out: assert property (@(posedge clk) disable iff (rst)
        (port_d_oe && !cfg_wide) |-> (port_d_o[15:8] == 8'h00));

    a_r4_narrow_push: assert property (@(posedge clk) disable iff (rst)
        (fifo_push && !cfg_wide) |-> (fifo_wdata[15:8] == 8'h00));

    a_r3_slave_quiet: assert property (@(posedge clk) disable iff (rst)
        !cfg_master |-> (port_ack_n_o && port_rd_n_o && port_wr_n_o));

    a_r2_req_before_ack: assert property (@(posedge clk) disable iff (rst)
        $fell(port_ack_n_o) |-> $past(port_req_o));

    a_r2_ack_one_cycle: assert property (@(posedge clk) disable iff (rst)
        !port_ack_n_o |=> port_ack_n_o);

    a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind dma_port_hs dma_port_hs_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_master   (cfg_master),
    .cfg_wide     (cfg_wide),
    .cfg_to_fifo  (cfg_to_fifo),
    .port_req_o   (port_req_o),
    .port_ack_n_o (port_ack_n_o),
    .port_rd_n_o  (port_rd_n_o),
    .port_wr_n_o  (port_wr_n_o),
    .port_rd_n_i  (port_rd_n_i),
    .port_d_o     (port_d_o),
    .port_d_oe    (port_d_oe),
    .fifo_empty   (fifo_empty),
    .fifo_push    (fifo_push),
    .fifo_wdata   (fifo_wdata),
    .fifo_pop     (fifo_pop),
    .busy         (busy),
    .done         (done)
);

// File: tb/dma_port_hs_bench.sv
module dma_port_hs_bench;
    localparam int CNT_W = 16;

    typedef struct packed {
        logic       m;
        logic       w;
        logic       t;
        logic [7:0] cnt;
        logic [7:0] beats;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b1, 8'd4, 8'd4},
        '{1'b1, 1'b1, 1'b1, 8'd6, 8'd3},
        '{1'b1, 1'b1, 1'b0, 8'd5, 8'd3},
        '{1'b1, 1'b0, 1'b0, 8'd3, 8'd3},
        '{1'b0, 1'b0, 1'b1, 8'd3, 8'd3},
        '{1'b0, 1'b1, 1'b1, 8'd4, 8'd2},
        '{1'b0, 1'b1, 1'b0, 8'd3, 8'd2},
        '{1'b0, 1'b0, 1'b0, 8'd2, 8'd2}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_master = 1'b1, cfg_wide = 1'b0, cfg_to_fifo = 1'b1;
    logic start = 1'b0, stop = 1'b0;
    logic [CNT_W-1:0] start_count = '0;
    logic port_req_o, port_ack_n_o, port_rd_n_o, port_wr_n_o;
    logic port_ack_n_i = 1'b1, port_rd_n_i = 1'b1, port_wr_n_i = 1'b1;
    logic [15:0] port_d_i, port_d_o, fifo_rdata, fifo_wdata;
    logic port_d_oe, fifo_push, fifo_pop, busy, done, done_by_stop;
    logic fifo_full = 1'b0, fifo_empty = 1'b0;

    int errors = 0;
    int checks = 0;
    int push_cnt = 0;
    int pop_cnt = 0;
    logic cnt_clr = 1'b0;
    logic ext_en = 1'b0;
    logic finished = 1'b0;

    always #4 clk = ~clk;

    dma_port_hs #(.CNT_W(CNT_W)) u_dma_port_hs (
        .clk(clk), .rst(rst),
        .cfg_master(cfg_master), .cfg_wide(cfg_wide), .cfg_to_fifo(cfg_to_fifo),
        .start(start), .stop(stop), .start_count(start_count),
        .port_req_o(port_req_o), .port_ack_n_o(port_ack_n_o),
        .port_rd_n_o(port_rd_n_o), .port_wr_n_o(port_wr_n_o),
        .port_ack_n_i(port_ack_n_i), .port_rd_n_i(port_rd_n_i), .port_wr_n_i(port_wr_n_i),
        .port_d_i(port_d_i), .port_d_o(port_d_o), .port_d_oe(port_d_oe),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
        .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .fifo_pop(fifo_pop),
        .busy(busy), .done(done), .done_by_stop(done_by_stop)
    );

    function automatic logic [15:0] exp_mask(input logic [15:0] d, input logic w);
        return w ? d : {8'h00, d[7:0]};
    endfunction

    assign port_d_i   = 16'hA5C0 ^ 16'(push_cnt * 16'h0111);
    assign fifo_rdata = 16'h5A30 + 16'(pop_cnt * 16'h0203);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // model FIFO side counters, advanced on the same edge the design acts on
    always @(posedge clk) begin
        if (cnt_clr) begin
            push_cnt <= 0;
            pop_cnt  <= 0;
        end else begin
            if (fifo_push) push_cnt <= push_cnt + 1;
            if (fifo_pop)  pop_cnt  <= pop_cnt + 1;
        end
    end

    // per-cycle data and handshake checks
    always @(negedge clk) begin
        if (!rst && busy) begin
            if (fifo_push)
                check(fifo_wdata == exp_mask(16'hA5C0 ^ 16'(push_cnt * 16'h0111), cfg_wide),
                      "R4 push data", fifo_wdata,
                      exp_mask(16'hA5C0 ^ 16'(push_cnt * 16'h0111), cfg_wide));
            if (port_d_oe)
                check(port_d_o == exp_mask(16'h5A30 + 16'((pop_cnt - 1) * 16'h0203), cfg_wide),
                      "R4 port out data", port_d_o,
                      exp_mask(16'h5A30 + 16'((pop_cnt - 1) * 16'h0203), cfg_wide));
            if (cfg_master && !port_ack_n_o)
                check(port_req_o && (cfg_to_fifo ? (!port_wr_n_o && port_rd_n_o && fifo_push)
                                                 : (!port_rd_n_o && port_wr_n_o && port_d_oe)),
                      "R2 master strobe", {port_req_o, port_rd_n_o, port_wr_n_o}, 0);
            if (!cfg_master)
                check(port_ack_n_o && port_rd_n_o && port_wr_n_o,
                      "R3 slave outputs idle", {port_ack_n_o, port_rd_n_o, port_wr_n_o}, 7);
            if (port_d_oe)
                check(!cfg_to_fifo && (cfg_master ? !port_rd_n_o : !port_rd_n_i),
                      "R8 oe with read strobe", port_d_oe, 0);
        end
    end

    // external initiator for responder-role transfers
    always begin
        @(negedge clk);
        if (ext_en && port_req_o) begin
            port_ack_n_i = 1'b0;
            if (cfg_to_fifo) port_wr_n_i = 1'b0;
            else             port_rd_n_i = 1'b0;
            repeat (4) @(negedge clk);
            port_ack_n_i = 1'b1;
            port_wr_n_i  = 1'b1;
            port_rd_n_i  = 1'b1;
            repeat (3) @(negedge clk);
        end
    end

    task automatic clear_counts();
        @(negedge clk);
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
    endtask

    task automatic kick(input logic m, input logic w, input logic t, input int cnt);
        cfg_master  = m;
        cfg_wide    = w;
        cfg_to_fifo = t;
        ext_en      = !m;
        clear_counts();
        start_count = CNT_W'(cnt);
        start       = 1'b1;
        @(negedge clk);
        start       = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(done == 1'b1, tag, done, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !port_req_o && port_ack_n_o && port_rd_n_o && port_wr_n_o
              && !port_d_oe && !fifo_push && !fifo_pop,
              "R1 reset outputs", {busy, done, port_req_o, fifo_push, fifo_pop}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !port_req_o && port_ack_n_o && !fifo_push && !fifo_pop,
              "R1 after reset", {busy, done, port_req_o}, 0);

        // table of transfers: R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            kick(VEC[i].m, VEC[i].w, VEC[i].t, int'(VEC[i].cnt));
            wait_done("R5 done reached");
            @(negedge clk);
            check(push_cnt + pop_cnt == int'(VEC[i].beats), "R5 beat count",
                  push_cnt + pop_cnt, VEC[i].beats);
            check(VEC[i].t ? (pop_cnt == 0) : (push_cnt == 0), "R2 direction of FIFO access",
                  VEC[i].t ? pop_cnt : push_cnt, 0);
            check(!done_by_stop && !busy, "R5 end by count", {done_by_stop, busy}, 0);
        end

        // R5 zero count
        kick(1'b1, 1'b0, 1'b1, 0);
        wait_done("R5 zero count done");
        check(push_cnt == 0 && !done_by_stop, "R5 zero count no beat", push_cnt, 0);

        // R7 stall on full
        fifo_full = 1'b1;
        kick(1'b1, 1'b0, 1'b1, 4);
        begin
            int bad = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (fifo_push || port_req_o) bad++;
            end
            check(bad == 0 && busy, "R7 no beat while full", bad, 0);
        end
        fifo_full = 1'b0;
        wait_done("R7 resume after full");
        check(push_cnt == 4, "R7 beats after full clears", push_cnt, 4);

        // R7 stall on empty, responder role
        fifo_empty = 1'b1;
        kick(1'b0, 1'b1, 1'b0, 4);
        begin
            int bad = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (fifo_pop || port_req_o) bad++;
            end
            check(bad == 0 && busy, "R7 no beat while empty", bad, 0);
        end
        fifo_empty = 1'b0;
        wait_done("R7 resume after empty");
        check(pop_cnt == 2, "R7 beats after empty clears", pop_cnt, 2);

        // R6 stop part way
        kick(1'b1, 1'b0, 1'b1, 200);
        repeat (10) @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        wait_done("R6 stop ends transfer");
        check(done_by_stop == 1'b1, "R6 end reason stop", done_by_stop, 1);
        check(push_cnt > 0 && push_cnt < 200, "R6 partial beats", push_cnt, 5);
        check(port_ack_n_o && port_wr_n_o && !busy, "R6 handshake released",
              {port_ack_n_o, port_wr_n_o, busy}, 6);

        // R9 start while busy
        kick(1'b1, 1'b0, 1'b1, 6);
        repeat (3) @(negedge clk);
        start_count = CNT_W'(50);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R9 done");
        @(negedge clk);
        check(push_cnt == 6, "R9 restart ignored", push_cnt, 6);

        // R10 pop never while empty: empty rises while idle, start draining
        fifo_empty = 1'b1;
        kick(1'b1, 1'b0, 1'b0, 2);
        repeat (10) @(negedge clk);
        check(pop_cnt == 0, "R10 no pop while empty", pop_cnt, 0);
        fifo_empty = 1'b0;
        wait_done("R10 done");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule